// File: doc/BRIEF.md
# Cascadable Programmable Clock Divider

This block turns a set of slow clock levels into divided clocks for downstream logic. All of its logic runs on one fast reference clock. Each source clock arrives as a level that is sampled on that reference clock. Each of the divider stages picks one source level and can invert it before use. The stage counts rising edges of the chosen level and produces a clock whose period is N source periods, with N set from 1 to 256. A stage can also pass the chosen level straight through, and it can invert its output. Stage 1 and later can take the output of the stage before them as a source, so two stages in series give a larger total ratio.

A small word-addressed register port sets the configuration. Stage s has one configuration word at word address 2*s. One control word sits just past the stage words. The control word holds a global divider enable, the input-inversion bits and two clock-gating modes. The gating modes are decoded into two gate-enable outputs: one for a bus clock and one for a register clock. In the dynamic modes, these outputs follow external request inputs.

Top module: `clkg_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, every clk_out bit is 0, and both gate outputs are 0, even with bus_req high and reg_req low.
- R2: Stage s's configuration word is at word address 2*s. Its 13 bits read back as written. The control word is at word address 2*NSTAGE and reads back its low 4+NSTAGE bits. Higher bits read 0.
- R3: Control bits [1:0] set the bus gating mode. 0 forces bus_gate low. 2 makes bus_gate follow bus_req. 3 holds bus_gate high. The value 1 acts like 0 but reads back as 1.
- R4: Control bit 3 set to 1 holds reg_gate high. Set to 0, reg_gate follows reg_req.
- R5: When control bit 2 (the enable) is 0, every clk_out bit stays 0. This holds for divided, bypassed and inverted outputs.
- R6: Configuration bits [12:5] hold N-1. For N of 2 or more, the output is high for ceil(N/2) source periods and low for floor(N/2) source periods. For N = 1, the output follows the source level.
- R7: A new ratio written while the stage runs takes effect only at the end of the current output period. Until then, no high or low phase of any other length appears.
- R8: Configuration bits [4:2] pick source code k, which is src_clk[k]. For stages after stage 0, code 0 picks the output of the previous stage instead.
- R9: Control bit 4+s inverts the source level that stage s uses.
- R10: Configuration bit 1 inverts the stage output on both the divided path and the bypass path.
- R11: Configuration bit 0 makes the stage output follow the selected source level, whatever ratio is set.
- R12: Writes to odd word addresses, and to addresses above the control word, change no register. Those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Word address |
| reg_wdata | input | 13 | Write data |
| reg_rdata | output | 13 | Read data, combinational from address |
| src_clk | input | 8 | Source clock levels, sampled on clk |
| bus_req | input | 1 | Bus activity request for dynamic gating |
| reg_req | input | 1 | Register activity request for dynamic gating |
| clk_out | output | NSTAGE (2) | Stage output clock levels |
| bus_gate | output | 1 | Bus clock gate enable |
| reg_gate | output | 1 | Register clock gate enable |

## Verification
The hardest case to reach is a ratio that changes partway through an output period. The bench first runs a ratio of 8, then writes a ratio of 2 at a point that does not line up with the output. It then measures several high and low phases in a row and checks that each one has either the old length or the new length. This shows that no shortened phase appears at the change. The cascade path needs the same kind of setup: stage 1 counts the output of stage 0, so the bench measures the combined ratio from the ports.

// File: rtl/clkg_pkg.sv
// Shared widths and types for the clock divider.
// Assumes: one configuration word per stage, packed with the fields from MSB to LSB.
package clkg_pkg;
    localparam int DIV_W = 8;               // ratio-minus-one field width
    localparam int SEL_W = 3;               // source select width
    localparam int NSRC  = 1 << SEL_W;      // number of source inputs
    localparam int CFG_W = DIV_W + SEL_W + 2;

    // Field order sets the bit positions: [12:5] ratio, [4:2] select, [1] inv, [0] bypass
    typedef struct packed {
        logic [DIV_W-1:0] ratio_m1;
        logic [SEL_W-1:0] sel;
        logic             out_inv;
        logic             bypass;
    } stage_cfg_t;

    typedef enum logic [1:0] {
        BUS_OFF = 2'd0,
        BUS_RSV = 2'd1,
        BUS_DYN = 2'd2,
        BUS_ON  = 2'd3
    } bus_mode_t;
endpackage

// File: rtl/clkg_regs.sv
// Register file for the clock divider: per-stage configuration words at
// even word addresses 2*s, and a control word at 2*NSTAGE.
// Assumes: single-cycle writes and a combinational read mux; reserved addresses read 0.
module clkg_regs
    import clkg_pkg::*;
#(
    parameter int NSTAGE = 2,
    parameter int ADDR_W = 3,
    parameter int CTL_W  = 4 + NSTAGE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CFG_W-1:0]  wdata_i,
    output logic [CFG_W-1:0]  rdata_o,
    output logic [CTL_W-1:0]  ctl_o,
    output stage_cfg_t        cfg_o [NSTAGE]
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(2 * NSTAGE);

    logic [CTL_W-1:0] ctl_q;
    stage_cfg_t       cfg_q [NSTAGE];
    logic             hit;

    // Register writes; only decoded addresses update storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int s = 0; s < NSTAGE; s++) cfg_q[s] <= '0;
        end else if (we_i) begin
            if (addr_i == CTL_ADDR) ctl_q <= wdata_i[CTL_W-1:0];
            for (int s = 0; s < NSTAGE; s++)
                if (addr_i == ADDR_W'(2 * s)) cfg_q[s] <= stage_cfg_t'(wdata_i);
        end
    end

    // Read mux and address hit decode
    always_comb begin
        rdata_o = '0;
        hit     = 1'b0;
        if (addr_i == CTL_ADDR) begin
            rdata_o = CFG_W'(ctl_q);
            hit     = 1'b1;
        end
        for (int s = 0; s < NSTAGE; s++) begin
            if (addr_i == ADDR_W'(2 * s)) begin
                rdata_o = cfg_q[s];
                hit     = 1'b1;
            end
        end
    end

    assign ctl_o = ctl_q;
    assign cfg_o = cfg_q;

    // R12
    rsv_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !hit) |=> $stable(ctl_q));

    for (genvar g = 0; g < NSTAGE; g++) begin : g_rsv
        // R12
        rsv_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && !hit) |=> $stable(cfg_q[g]));
    end
endmodule

// File: rtl/clkg_stage.sv
// One divider stage. It picks a source level, optionally inverts it, and counts
// its rising edges on the reference clock. It outputs the divided clock
// (high ceil(N/2) periods), the raw level (bypass or N = 1), optionally inverted.
// Assumes: source levels change at most once per reference cycle; the new ratio loads at terminal count.
module clkg_stage
    import clkg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            in_inv_i,
    input  stage_cfg_t      cfg_i,
    input  logic [NSRC-1:0] src_i,
    output logic            out_o
);
    logic             sel_lvl, lvl_q, rise, term, dq_q, base;
    logic [DIV_W-1:0] cnt_q, div_q, cnt_nx, div_nx;
    logic [DIV_W:0]   hi_len;

    // Source selection, edge detect and next-count values
    always_comb begin
        sel_lvl = src_i[cfg_i.sel] ^ in_inv_i;
        rise    = sel_lvl & ~lvl_q;
        term    = (cnt_q == div_q);
        cnt_nx  = term ? '0 : cnt_q + DIV_W'(1);
        div_nx  = term ? cfg_i.ratio_m1 : div_q;
        hi_len  = ({1'b0, div_nx} + (DIV_W+1)'(2)) >> 1;
    end

    // Divider state: the level history, the counter, the active ratio and the divided level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
            div_q <= '0;
            dq_q  <= 1'b0;
        end else begin
            lvl_q <= sel_lvl;
            if (!en_i) begin
                cnt_q <= '0;
                div_q <= cfg_i.ratio_m1;
                dq_q  <= 1'b0;
            end else if (rise) begin
                cnt_q <= cnt_nx;
                div_q <= div_nx;
                dq_q  <= ({1'b0, cnt_nx} < hi_len);
            end
        end
    end

    // Output path selection with inversion and global gating
    always_comb begin
        base  = (cfg_i.bypass || div_q == '0) ? lvl_q : dq_q;
        out_o = en_i & (base ^ cfg_i.out_inv);
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_q);

    // R7
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !(rise && term)) |=> $stable(div_q));

    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0 && !dq_q));
endmodule

// File: rtl/clkg_gate.sv
// Decodes the bus-clock and register-clock gating modes into gate enables.
// Assumes: the reserved bus mode acts as off; request inputs are synchronous to clk.
module clkg_gate
    import clkg_pkg::*;
(
    input  bus_mode_t bus_mode_i,
    input  logic      reg_on_i,
    input  logic      bus_req_i,
    input  logic      reg_req_i,
    output logic      bus_gate_o,
    output logic      reg_gate_o
);
    // Mode decode for both gate enables
    always_comb begin
        unique case (bus_mode_i)
            BUS_DYN: bus_gate_o = bus_req_i;
            BUS_ON:  bus_gate_o = 1'b1;
            default: bus_gate_o = 1'b0;
        endcase
        reg_gate_o = reg_on_i | reg_req_i;
    end
endmodule

// File: rtl/clkg_top.sv
// Top of the cascadable clock divider: register file, NSTAGE divider stages
// (each stage after stage 0 sees the previous output on source code 0) and gate decode.
// Assumes: all sources are levels sampled on clk; synchronous active-low reset.
module clkg_top
    import clkg_pkg::*;
#(
    parameter int NSTAGE = 2,
    parameter int ADDR_W = $clog2(2 * NSTAGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [CFG_W-1:0]  reg_rdata,
    input  logic [NSRC-1:0]   src_clk,
    input  logic              bus_req,
    input  logic              reg_req,
    output logic [NSTAGE-1:0] clk_out,
    output logic              bus_gate,
    output logic              reg_gate
);
    localparam int CTL_W   = 4 + NSTAGE;
    localparam int EN_BIT  = 2;
    localparam int REG_BIT = 3;
    localparam int INV_LSB = 4;

    logic [CTL_W-1:0] ctl;
    stage_cfg_t       cfg [NSTAGE];
    logic [NSRC-1:0]  ssrc [NSTAGE];
    logic             stg_out [NSTAGE];

    clkg_regs #(.NSTAGE(NSTAGE), .ADDR_W(ADDR_W), .CTL_W(CTL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .ctl_o   (ctl),
        .cfg_o   (cfg)
    );

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign ssrc[s] = src_clk;
        end else begin : g_casc
            assign ssrc[s] = {src_clk[NSRC-1:1], stg_out[s-1]};
        end

        clkg_stage u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (ctl[EN_BIT]),
            .in_inv_i (ctl[INV_LSB + s]),
            .cfg_i    (cfg[s]),
            .src_i    (ssrc[s]),
            .out_o    (stg_out[s])
        );

        assign clk_out[s] = stg_out[s];
    end

    clkg_gate u_gate (
        .bus_mode_i (bus_mode_t'(ctl[1:0])),
        .reg_on_i   (ctl[REG_BIT]),
        .bus_req_i  (bus_req),
        .reg_req_i  (reg_req),
        .bus_gate_o (bus_gate),
        .reg_gate_o (reg_gate)
    );

    // R3
    bus_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[1:0] == 2'd1) |-> !bus_gate);

    // R4
    reg_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[REG_BIT] |-> reg_gate);
endmodule

// File: tb/clkg_top_tb.sv
`timescale 1ns/1ps
module clkg_top_tb;
    localparam int NST = 2;
    localparam int AW  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [12:0] reg_wdata = '0;
    logic [12:0] reg_rdata;
    logic [7:0]  src_clk = '0;
    logic        bus_req = 1'b0;
    logic        reg_req = 1'b0;
    logic [NST-1:0] clk_out;
    logic        bus_gate, reg_gate;

    int n_chk = 0;
    int n_bad = 0;

    clkg_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_clk(src_clk),
        .bus_req(bus_req), .reg_req(reg_req), .clk_out(clk_out),
        .bus_gate(bus_gate), .reg_gate(reg_gate)
    );

    always #10 clk = ~clk;

    // Source k toggles every k+1 reference cycles, changed 2 ns after a rising edge
    initial begin
        int hc [8];
        for (int i = 0; i < 8; i++) hc[i] = 0;
        forever begin
            @(posedge clk);
            #2;
            for (int i = 0; i < 8; i++) begin
                if (hc[i] == i) begin
                    hc[i] = 0;
                    src_clk[i] = ~src_clk[i];
                end else hc[i] = hc[i] + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = 13'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = int'(reg_rdata);
    endtask

    function automatic int mk(input int n, input int sel, input int oinv, input int byp);
        return (((n - 1) & 255) << 5) | (sel << 2) | (oinv << 1) | byp;
    endfunction

    // Measures one full high phase and the low phase after it, sampled at falling edges
    task automatic get_run(input int stg, output int hi, output int lo);
        int g = 0;
        hi = 0; lo = 0;
        @(negedge clk);
        while (clk_out[stg] !== 1'b0 && g < 6000) begin @(negedge clk); g++; end
        while (clk_out[stg] !== 1'b1 && g < 6000) begin @(negedge clk); g++; end
        while (clk_out[stg] === 1'b1 && g < 6000) begin hi++; @(negedge clk); g++; end
        while (clk_out[stg] === 1'b0 && g < 6000) begin lo++; @(negedge clk); g++; end
    endtask

    // Checks that the output equals the source level from one cycle earlier, optionally inverted
    task automatic lag_cmp(input string tag, input int stg, input int si, input logic inv);
        logic prev;
        int bad = 0;
        repeat (20) @(negedge clk);
        prev = src_clk[si];
        repeat (40) begin
            @(negedge clk);
            if (clk_out[stg] !== (prev ^ inv)) bad++;
            prev = src_clk[si];
        end
        chk(tag, bad, 0);
    endtask

    task automatic div_chk(input string tag, input int stg, input int n, input int h, input int oinv);
        int hi, lo, ehi, elo;
        get_run(stg, hi, lo);
        get_run(stg, hi, lo);
        if (n == 1) begin ehi = h; elo = h; end
        else begin ehi = ((n + 1) / 2) * 2 * h; elo = (n / 2) * 2 * h; end
        if (oinv != 0 && n > 1) begin int t = ehi; ehi = elo; elo = t; end
        chk({tag, " high"}, hi, ehi);
        chk({tag, " low"}, lo, elo);
    endtask

    initial begin
        #(20 * 190000);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int d, hi, lo, bad;
        repeat (4) @(negedge clk);
        bus_req = 1'b1;
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 5; a++) begin rd(a, d); chk("R1 reg reset", d, 0); end
        chk("R1 clk_out", int'(clk_out), 0);
        chk("R1 bus_gate", int'(bus_gate), 0);
        chk("R1 reg_gate", int'(reg_gate), 0);

        // R2: readback of stored bits and address map
        wr(0, 13'h1FFF); wr(2, 13'h0ABC); wr(4, 13'h1FFF);
        rd(0, d); chk("R2 cfg0", d, 'h1FFF);
        rd(2, d); chk("R2 cfg1", d, 'h0ABC);
        rd(4, d); chk("R2 ctl", d, 'h3F);

        // R12: reserved addresses ignored and read 0
        for (int a = 1; a < 8; a++) begin
            if (a % 2 == 1 || a > 4) begin
                wr(a, 13'h0155);
                rd(a, d); chk("R12 rsv read", d, 0);
            end
        end
        rd(0, d); chk("R12 cfg0 kept", d, 'h1FFF);
        rd(2, d); chk("R12 cfg1 kept", d, 'h0ABC);
        rd(4, d); chk("R12 ctl kept", d, 'h3F);
        wr(0, 0); wr(2, 0); wr(4, 0);

        // R3/R4: gating modes over all mode and request combinations
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 2; r++) begin
                for (int rm = 0; rm < 2; rm++) begin
                    wr(4, m | (rm << 3));
                    bus_req = r[0]; reg_req = r[0];
                    @(negedge clk);
                    chk("R3 bus_gate", int'(bus_gate), (m == 3) ? 1 : ((m == 2) ? r : 0));
                    chk("R4 reg_gate", int'(reg_gate), (rm == 1) ? 1 : r);
                end
            end
        end
        wr(4, 1); rd(4, d); chk("R3 reserved readback", d, 1);
        bus_req = 1'b0; reg_req = 1'b0;

        // R6/R8: divide sweep over all sources on stage 0
        wr(4, 4);
        for (int s = 0; s < 8; s++) begin
            for (int n = 1; n <= 6; n++) begin
                wr(0, mk(n, s, 0, 0));
                div_chk($sformatf("R6 R8 src%0d n%0d", s, n), 0, n, s + 1, 0);
            end
        end
        wr(0, mk(256, 0, 0, 0)); div_chk("R6 n256", 0, 256, 1, 0);
        wr(0, mk(255, 0, 0, 0)); div_chk("R6 n255", 0, 255, 1, 0);
        // R10: output inversion on divided path
        wr(0, mk(5, 1, 1, 0)); div_chk("R10 inv n5", 0, 5, 2, 1);

        // R7: ratio change lands at terminal count
        wr(0, mk(8, 0, 0, 0));
        get_run(0, hi, lo); get_run(0, hi, lo);
        repeat (3) @(negedge clk);
        wr(0, mk(2, 0, 0, 0));
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            get_run(0, hi, lo);
            if (!(hi == 2 || hi == 8)) bad++;
            if (!(lo == 2 || lo == 8)) bad++;
        end
        chk("R7 no runt", bad, 0);
        chk("R7 new high", hi, 2);
        chk("R7 new low", lo, 2);

        // R11: bypass follows source regardless of ratio; R10 with bypass
        wr(0, mk(5, 1, 0, 1)); lag_cmp("R11 bypass", 0, 1, 1'b0);
        wr(0, mk(5, 1, 1, 1)); lag_cmp("R10 bypass inv", 0, 1, 1'b1);

        // R9: input inversion on both stages
        wr(0, mk(1, 2, 0, 0)); wr(4, 4 | 16); lag_cmp("R9 stage0 inv", 0, 2, 1'b1);
        wr(4, 4);               lag_cmp("R9 stage0 plain", 0, 2, 1'b0);
        wr(2, mk(1, 3, 0, 0)); wr(4, 4 | 32); lag_cmp("R9 stage1 inv", 1, 3, 1'b1);

        // R8: stage 1 cascade on code 0, direct source otherwise
        wr(4, 4);
        wr(0, mk(3, 0, 0, 0)); wr(2, mk(2, 0, 0, 0));
        get_run(1, hi, lo); get_run(1, hi, lo);
        chk("R8 cascade high", hi, 6);
        chk("R8 cascade low", lo, 6);
        wr(2, mk(3, 3, 0, 0)); div_chk("R8 stage1 src3", 1, 3, 4, 0);

        // R5: enable clear silences divided and bypassed outputs
        wr(2, mk(1, 1, 1, 1));
        wr(4, 0);
        repeat (3) @(negedge clk);
        bad = 0;
        repeat (30) begin @(negedge clk); if (clk_out !== 2'b00) bad++; end
        chk("R5 disabled quiet", bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule